// File: doc/BRIEF.md
# Vector Element Loop Sequencer

This block sits between instruction decode and issue. It takes one decoded vector instruction and turns it into an ordered series of per-element issue requests, one for each element index between the current start index and the vector length minus one. For every element, each operand flagged as a vector gets its register number offset by the element index. An operand flagged as scalar keeps its base register number on every element.

The element index and the vector length live in a 32-bit loop-state register. This register acts as a sub-program-counter and is part of architectural state. The loop can be stopped between any two elements by an exception. When that happens, the whole loop-state word is copied into a 32-bit save register, at the same moment the core saves its PC and MSR. A return-from-exception strobe reloads the loop-state register from the save register, so the re-decoded instruction resumes at the element where it stopped.

Both registers are reachable through a simple SPR read/write port. The loop-state register is number 704 and needs no privilege. The save register is number 720 and needs privilege. A prefixed instruction that is not in the vector-extendable set is refused with a one-cycle illegal pulse.

Top module: `vls_seq`

## Requirements
- R1: While running, `iss_valid` is high. Elements are presented strictly in ascending index order, from the start index up to VL-1, and `iss_step` carries the index. Each index is issued exactly once.
- R2: For operand k (field `[k*7 +: 7]` of the base and issue buses; k=3 is the implicit condition-register operand), the issued number is the base plus the element index when `dec_isvec[k]` is 1, and the unchanged base when it is 0. Only that flag affects the CR operand.
- R3: An adjusted register number wraps modulo 128, so base 126 at index 3 gives 1.
- R4: The index advances only in a cycle where `iss_valid` and `iss_ready` are both high. When element VL-1 is accepted, the index returns to 0, `busy` drops, and `done` is high for the following cycle.
- R5: If the start index is not below VL (for example VL=0), a legal instruction issues no element. `done` pulses once and the index is left at 0.
- R6: A valid instruction with `dec_ext` low issues no element and keeps `busy` low. `illegal` is high for the following cycle.
- R7: In a cycle where `exc_req` is high, no element is issued. The full loop-state word is copied into the save register and the loop stops with the index held.
- R8: A `rfe` strobe while idle reloads the loop-state register from the save register. The next instruction then starts at the saved index and not at 0.
- R9: SPR 704 reads and writes the loop-state word at any privilege. The index is bits [6:0] and VL is bits [14:8]. SPR 720 is the save register. With `spr_priv` low, a read of 720 returns 0 and a write to 720 is ignored. Other numbers read 0.
- R10: A write to SPR 704 while idle sets the start index for the next instruction. SPR writes while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decoded prefixed instruction present (taken when idle) |
| dec_ext | input | 1 | Instruction is in the vector-extendable set |
| dec_base | input | 28 | Four 7-bit base register numbers (dst, srcA, srcB, CR) |
| dec_isvec | input | 4 | Per-operand vector flag |
| iss_ready | input | 1 | Issue stage accepts the current element |
| exc_req | input | 1 | Take an exception this cycle |
| rfe | input | 1 | Return-from-exception strobe |
| spr_wr | input | 1 | SPR write enable |
| spr_priv | input | 1 | Access is privileged |
| spr_num | input | 10 | SPR number |
| spr_wdata | input | 32 | SPR write data |
| spr_rdata | output | 32 | SPR read data (combinational) |
| iss_valid | output | 1 | Element issue request |
| iss_step | output | 7 | Element index of the request |
| iss_reg | output | 28 | Adjusted register numbers, same packing as `dec_base` |
| busy | output | 1 | A vector instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-instruction pulse |

## Verification
The bound checker watches the per-cycle rules on every cycle: the index holds under back-pressure and steps by one on acceptance, nothing is issued during an exception cycle or together with an illegal pulse, `done` never coincides with `busy`, and an unprivileged read of the save register returns zero. The bench's scenarios show what needs a whole sequence. That covers the element order and operand numbers against a scoreboard, including wraparound and scalar operands. It also covers the VL=0 and non-extendable cases, the save of the state word on an exception, and the resume from the saved index after the return strobe. Finally it shows that SPR writes take effect while idle and are ignored while busy.

// File: rtl/vls_pkg.sv
package vls_pkg;

    localparam int REG_W      = 7;
    localparam int NUM_OPS    = 4;
    localparam int STEP_W     = 7;
    localparam int VL_W       = STEP_W;
    localparam int STEP_LSB   = 0;
    localparam int VL_LSB     = 8;
    localparam int STATE_W    = 32;
    localparam int SPRN_W     = 10;
    localparam int SPRN_STATE = 704;
    localparam int SPRN_SAVE  = 720;
    localparam int OPS_W      = NUM_OPS * REG_W;

    typedef logic [STEP_W-1:0]  step_t;
    typedef logic [VL_W-1:0]    vl_t;
    typedef logic [STATE_W-1:0] state_t;

    typedef struct packed {
        logic [OPS_W-1:0]   base;
        logic [NUM_OPS-1:0] isvec;
    } vinstr_t;

    typedef enum logic [0:0] {
        LOOP_IDLE = 1'b0,
        LOOP_RUN  = 1'b1
    } loop_st_e;

    function automatic step_t state_step(input state_t s);
        return s[STEP_LSB +: STEP_W];
    endfunction

    function automatic vl_t state_vl(input state_t s);
        return s[VL_LSB +: VL_W];
    endfunction

endpackage

// File: rtl/vls_regadj.sv
module vls_regadj #(
    parameter int NOPS = vls_pkg::NUM_OPS,
    parameter int RW   = vls_pkg::REG_W,
    parameter int SW   = vls_pkg::STEP_W
) (
    input  logic [NOPS*RW-1:0] base_i,
    input  logic [NOPS-1:0]    vec_i,
    input  logic [SW-1:0]      step_i,
    output logic [NOPS*RW-1:0] reg_o
);
    logic [RW-1:0] step_r;
    assign step_r = RW'(step_i);

    for (genvar k = 0; k < NOPS; k++) begin : g_op
        logic [RW-1:0] b;
        assign b = base_i[k*RW +: RW];
        // modulo-2^RW wrap falls out of the truncated sum
        assign reg_o[k*RW +: RW] = vec_i[k] ? (b + step_r) : b;
    end
endmodule

// File: rtl/vls_sprfile.sv
module vls_sprfile
    import vls_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              spr_wr,
    input  logic              spr_priv,
    input  logic [SPRN_W-1:0] spr_num,
    input  state_t            spr_wdata,
    output state_t            spr_rdata,
    input  logic              wr_allow,
    input  logic              exc_save,
    input  logic              rfe_load,
    input  logic              step_we,
    input  step_t             step_val,
    output state_t            state_q,
    output state_t            save_q
);
    logic hit_state, hit_save, wr_state, wr_save;

    assign hit_state = (spr_num == SPRN_W'(SPRN_STATE));
    assign hit_save  = (spr_num == SPRN_W'(SPRN_SAVE));
    assign wr_state  = spr_wr && wr_allow && hit_state;
    assign wr_save   = spr_wr && wr_allow && hit_save && spr_priv;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (rfe_load) begin
            state_q <= save_q;
        end else if (wr_state) begin
            state_q <= spr_wdata;
        end else if (step_we) begin
            state_q[STEP_LSB +: STEP_W] <= step_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            save_q <= '0;
        end else if (exc_save) begin
            save_q <= state_q;
        end else if (wr_save) begin
            save_q <= spr_wdata;
        end
    end

    always_comb begin
        if (hit_state)                 spr_rdata = state_q;
        else if (hit_save && spr_priv) spr_rdata = save_q;
        else                           spr_rdata = '0;
    end
endmodule

// File: rtl/vls_ctrl.sv
module vls_ctrl
    import vls_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  dec_valid,
    input  logic  dec_ext,
    input  logic  iss_ready,
    input  logic  exc_req,
    input  logic  rfe,
    input  step_t cur_step,
    input  vl_t   cur_vl,
    output logic  run,
    output logic  iss_valid,
    output logic  ld_instr,
    output logic  step_we,
    output step_t step_val,
    output logic  exc_save,
    output logic  rfe_load,
    output logic  wr_allow,
    output logic  done,
    output logic  illegal
);
    loop_st_e st_q, st_d;
    logic     done_d, illegal_d, accept, last, empty, start;
    step_t    step_nxt;

    assign run       = (st_q == LOOP_RUN);
    assign iss_valid = run && !exc_req;
    assign accept    = iss_valid && iss_ready;
    assign step_nxt  = cur_step + STEP_W'(1);
    assign last      = (step_nxt >= STEP_W'(cur_vl));
    assign empty     = (cur_step >= STEP_W'(cur_vl));
    assign exc_save  = exc_req;

    always_comb begin
        st_d      = st_q;
        done_d    = 1'b0;
        illegal_d = 1'b0;
        ld_instr  = 1'b0;
        step_we   = 1'b0;
        step_val  = '0;
        rfe_load  = 1'b0;
        wr_allow  = 1'b0;
        start     = 1'b0;
        unique case (st_q)
            LOOP_IDLE: begin
                rfe_load = rfe && !exc_req;
                wr_allow = !exc_req && !rfe;
                start    = dec_valid && !exc_req && !rfe;
                if (start && !dec_ext) begin
                    illegal_d = 1'b1;
                end else if (start && empty) begin
                    done_d  = 1'b1;
                    step_we = 1'b1;
                end else if (start) begin
                    ld_instr = 1'b1;
                    st_d     = LOOP_RUN;
                end
            end
            LOOP_RUN: begin
                if (exc_req) begin
                    st_d = LOOP_IDLE;
                end else if (accept && last) begin
                    step_we = 1'b1;
                    done_d  = 1'b1;
                    st_d    = LOOP_IDLE;
                end else if (accept) begin
                    step_we  = 1'b1;
                    step_val = step_nxt;
                end
            end
            default: st_d = LOOP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= LOOP_IDLE;
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            st_q    <= st_d;
            done    <= done_d;
            illegal <= illegal_d;
        end
    end
endmodule

// File: rtl/vls_seq.sv
module vls_seq
    import vls_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      dec_valid,
    input  logic                      dec_ext,
    input  logic [NUM_OPS*REG_W-1:0]  dec_base,
    input  logic [NUM_OPS-1:0]        dec_isvec,
    input  logic                      iss_ready,
    input  logic                      exc_req,
    input  logic                      rfe,
    input  logic                      spr_wr,
    input  logic                      spr_priv,
    input  logic [SPRN_W-1:0]         spr_num,
    input  logic [STATE_W-1:0]        spr_wdata,
    output logic [STATE_W-1:0]        spr_rdata,
    output logic                      iss_valid,
    output logic [STEP_W-1:0]         iss_step,
    output logic [NUM_OPS*REG_W-1:0]  iss_reg,
    output logic                      busy,
    output logic                      done,
    output logic                      illegal
);
    vinstr_t instr_q;
    state_t  state_q, save_q;
    step_t   cur_step, step_val;
    vl_t     cur_vl;
    logic    run, ld_instr, step_we, exc_save, rfe_load, wr_allow;

    assign cur_step = state_step(state_q);
    assign cur_vl   = state_vl(state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            instr_q <= '0;
        end else if (ld_instr) begin
            instr_q.base  <= dec_base;
            instr_q.isvec <= dec_isvec;
        end
    end

    vls_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .dec_valid (dec_valid),
        .dec_ext   (dec_ext),
        .iss_ready (iss_ready),
        .exc_req   (exc_req),
        .rfe       (rfe),
        .cur_step  (cur_step),
        .cur_vl    (cur_vl),
        .run       (run),
        .iss_valid (iss_valid),
        .ld_instr  (ld_instr),
        .step_we   (step_we),
        .step_val  (step_val),
        .exc_save  (exc_save),
        .rfe_load  (rfe_load),
        .wr_allow  (wr_allow),
        .done      (done),
        .illegal   (illegal)
    );

    vls_sprfile u_spr (
        .clk       (clk),
        .rst       (rst),
        .spr_wr    (spr_wr),
        .spr_priv  (spr_priv),
        .spr_num   (spr_num),
        .spr_wdata (spr_wdata),
        .spr_rdata (spr_rdata),
        .wr_allow  (wr_allow),
        .exc_save  (exc_save),
        .rfe_load  (rfe_load),
        .step_we   (step_we),
        .step_val  (step_val),
        .state_q   (state_q),
        .save_q    (save_q)
    );

    vls_regadj #(.NOPS(NUM_OPS), .RW(REG_W), .SW(STEP_W)) u_adj (
        .base_i (instr_q.base),
        .vec_i  (instr_q.isvec),
        .step_i (cur_step),
        .reg_o  (iss_reg)
    );

    assign iss_step = cur_step;
    assign busy     = run;
endmodule

// File: rtl/vls_seq_chk.sv
module vls_seq_chk
    import vls_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic [STEP_W-1:0] iss_step,
    input logic [VL_W-1:0]   cur_vl,
    input logic              busy,
    input logic              done,
    input logic              illegal,
    input logic              exc_req,
    input logic              spr_priv,
    input logic [SPRN_W-1:0] spr_num,
    input logic [STATE_W-1:0] spr_rdata
);
    // R1
    valid_busy_chk: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> busy);

    // R4
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready) |=> (iss_step == $past(iss_step)));

    // R4
    step_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready && ((iss_step + STEP_W'(1)) < STEP_W'(cur_vl)))
        |=> (iss_step == $past(iss_step) + STEP_W'(1)));

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6
    illegal_noissue_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !iss_valid);

    // R7
    exc_noissue_chk: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> !iss_valid);

    // R9
    save_priv_chk: assert property (@(posedge clk) disable iff (rst)
        (spr_num == SPRN_W'(SPRN_SAVE) && !spr_priv) |-> (spr_rdata == '0));
endmodule

bind vls_seq vls_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .iss_step  (iss_step),
    .cur_vl    (cur_vl),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal),
    .exc_req   (exc_req),
    .spr_priv  (spr_priv),
    .spr_num   (spr_num),
    .spr_rdata (spr_rdata)
);

// File: tb/sim_vls_seq.sv
`timescale 1ns/100ps
module sim_vls_seq;
    import vls_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dec_valid = 0, dec_ext = 1, iss_ready = 0, exc_req = 0, rfe = 0;
    logic spr_wr = 0, spr_priv = 0;
    logic [NUM_OPS*REG_W-1:0] dec_base = '0, iss_reg;
    logic [NUM_OPS-1:0] dec_isvec = '0;
    logic [SPRN_W-1:0] spr_num = '0;
    logic [31:0] spr_wdata = '0, spr_rdata;
    logic iss_valid, busy, done, illegal;
    logic [STEP_W-1:0] iss_step;

    always #2.5 clk = ~clk;

    vls_seq u0 (.*);

    typedef struct { int step; logic [NUM_OPS*REG_W-1:0] regs; } exp_t;
    exp_t q[$];
    exp_t e;
    int checks = 0, errors = 0;
    int acc_cnt = 0, done_cnt = 0, ill_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [NUM_OPS*REG_W-1:0] exp_regs(
        input logic [NUM_OPS*REG_W-1:0] b, input logic [NUM_OPS-1:0] v, input int s);
        logic [NUM_OPS*REG_W-1:0] r;
        for (int k = 0; k < NUM_OPS; k++) begin
            int bv = int'(b[k*REG_W +: REG_W]);
            r[k*REG_W +: REG_W] = v[k] ? REG_W'((bv + s) % (1 << REG_W)) : b[k*REG_W +: REG_W];
        end
        return r;
    endfunction

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        #1;
        if (!rst) begin
            if (iss_valid && iss_ready) begin
                if (q.size() == 0) begin
                    chk(0, "R1", "unexpected element", iss_step, -1);
                end else begin
                    e = q.pop_front();
                    chk(iss_step == e.step, "R1", "element index", iss_step, e.step);
                    chk(iss_reg == e.regs, "R2", "register numbers", iss_reg, e.regs);
                end
                acc_cnt++;
            end
            if (done) done_cnt++;
            if (illegal) ill_cnt++;
        end
    end

    task automatic spr_write(input int num, input logic [31:0] d, input bit priv);
        @(negedge clk);
        spr_wr = 1; spr_num = SPRN_W'(num); spr_wdata = d; spr_priv = priv;
        @(negedge clk);
        spr_wr = 0;
    endtask

    task automatic spr_read(input int num, input bit priv, output logic [31:0] v);
        @(negedge clk);
        spr_num = SPRN_W'(num); spr_priv = priv;
        #1 v = spr_rdata;
    endtask

    function automatic logic [31:0] st(input int vl, input int step);
        return (32'(vl) << VL_LSB) | 32'(step);
    endfunction

    task automatic run_vec(input logic [NUM_OPS*REG_W-1:0] b, input logic [NUM_OPS-1:0] v,
                           input int start, input int vl, input int intr,
                           input bit stall, input bit poke);
        int stop = (intr >= 0) ? start + intr : vl;
        int d0 = done_cnt;
        bit poked = 0;
        for (int s = start; s < stop; s++) q.push_back('{s, exp_regs(b, v, s)});
        acc_cnt = 0;
        @(negedge clk);
        dec_valid = 1; dec_ext = 1; dec_base = b; dec_isvec = v;
        @(negedge clk);
        dec_valid = 0;
        for (int c = 0; c < 400; c++) begin
            iss_ready = stall ? (c % 3 != 1) : 1'b1;
            if (poke && acc_cnt == 1 && !poked) begin
                spr_wr = 1; spr_num = SPRN_W'(SPRN_STATE); spr_wdata = 32'h0; poked = 1;
            end else begin
                spr_wr = 0;
            end
            if (intr >= 0 && acc_cnt == intr) begin
                exc_req = 1;
                @(negedge clk);
                exc_req = 0;
                break;
            end
            if (done_cnt != d0) break;
            @(negedge clk);
        end
        iss_ready = 0; spr_wr = 0;
        chk(q.size() == 0, "R1", "elements not issued", q.size(), 0);
        if (intr < 0) chk(done_cnt == d0 + 1, "R4", "done pulses", done_cnt - d0, 1);
        else          chk(done_cnt == d0, "R7", "done pulses after exception", done_cnt - d0, 0);
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1000000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 0;
        #1;
        chk(busy == 0, "R4", "busy after reset", busy, 0);
        chk(iss_valid == 0, "R1", "iss_valid after reset", iss_valid, 0);
        chk(done == 0, "R4", "done after reset", done, 0);
        spr_read(SPRN_STATE, 0, v);
        chk(v == 0, "R9", "state after reset", v, 0);
        spr_read(SPRN_SAVE, 1, v);
        chk(v == 0, "R9", "save after reset", v, 0);

        // basic: dst, srcA, CR vector; srcB scalar
        spr_write(SPRN_STATE, st(5, 0), 0);
        spr_read(SPRN_STATE, 0, v);
        chk(v == st(5, 0), "R9", "state write readback", v, st(5, 0));
        run_vec({7'd2, 7'd30, 7'd20, 7'd10}, 4'b1011, 0, 5, -1, 0, 0);
        spr_read(SPRN_STATE, 0, v);
        chk(v == st(5, 0), "R4", "index back to 0 after loop", v, st(5, 0));

        // stalls and a write while busy (R10 ignored)
        spr_write(SPRN_STATE, st(4, 0), 0);
        run_vec({7'd5, 7'd60, 7'd50, 7'd40}, 4'b0110, 0, 4, -1, 1, 1);
        spr_read(SPRN_STATE, 0, v);
        chk(v == st(4, 0), "R10", "busy write ignored", v, st(4, 0));

        // wrap
        spr_write(SPRN_STATE, st(5, 0), 0);
        run_vec({7'd127, 7'd3, 7'd125, 7'd126}, 4'b1111, 0, 5, -1, 0, 0);
        chk(exp_regs({7'd0, 7'd0, 7'd0, 7'd126}, 4'b0001, 3) == 28'd1, "R3", "wrap model", 0, 0);

        // VL = 0
        spr_write(SPRN_STATE, st(0, 0), 0);
        run_vec({7'd1, 7'd1, 7'd1, 7'd1}, 4'b1111, 0, 0, -1, 0, 0);
        chk(acc_cnt == 0, "R5", "elements for VL=0", acc_cnt, 0);
        spr_read(SPRN_STATE, 0, v);
        chk(v[6:0] == 0, "R5", "index after VL=0", v[6:0], 0);

        // non-extendable instruction
        spr_write(SPRN_STATE, st(3, 0), 0);
        acc_cnt = 0;
        @(negedge clk);
        dec_valid = 1; dec_ext = 0; iss_ready = 1;
        @(negedge clk);
        dec_valid = 0; dec_ext = 1;
        repeat (3) @(negedge clk);
        #1;
        chk(ill_cnt == 1, "R6", "illegal pulses", ill_cnt, 1);
        chk(busy == 0, "R6", "busy after illegal", busy, 0);
        chk(acc_cnt == 0, "R6", "elements after illegal", acc_cnt, 0);
        iss_ready = 0;

        // exception mid-vector then resume
        spr_write(SPRN_STATE, st(6, 0), 0);
        run_vec({7'd0, 7'd9, 7'd8, 7'd70}, 4'b0101, 0, 6, 2, 0, 0);
        #1;
        chk(busy == 0, "R7", "busy after exception", busy, 0);
        spr_read(SPRN_SAVE, 1, v);
        chk(v == st(6, 2), "R7", "saved state", v, st(6, 2));
        spr_read(SPRN_STATE, 0, v);
        chk(v == st(6, 2), "R7", "state held", v, st(6, 2));
        spr_write(SPRN_STATE, st(6, 0), 0);
        @(negedge clk); rfe = 1;
        @(negedge clk); rfe = 0;
        spr_read(SPRN_STATE, 0, v);
        chk(v == st(6, 2), "R8", "state reloaded", v, st(6, 2));
        run_vec({7'd0, 7'd9, 7'd8, 7'd70}, 4'b0101, 2, 6, -1, 0, 0);

        // privilege on save register
        spr_read(SPRN_SAVE, 0, v);
        chk(v == 0, "R9", "unprivileged save read", v, 0);
        spr_write(SPRN_SAVE, 32'h1234, 0);
        spr_read(SPRN_SAVE, 1, v);
        chk(v == st(6, 2), "R9", "unprivileged save write ignored", v, st(6, 2));
        spr_write(SPRN_SAVE, 32'h55, 1);
        spr_read(SPRN_SAVE, 1, v);
        chk(v == 32'h55, "R9", "privileged save write", v, 32'h55);

        // start index from SPR write
        spr_write(SPRN_STATE, st(5, 3), 0);
        run_vec({7'd11, 7'd22, 7'd33, 7'd44}, 4'b1001, 3, 5, -1, 0, 0);
        spr_read(SPRN_STATE, 0, v);
        chk(v == st(5, 0), "R10", "index after started run", v, st(5, 0));

        finish_up();
    end
endmodule